// File: doc/BRIEF.md
# Programmable Convolutional Byte De-Interleaver

This block reverses a convolutional byte interleave. Incoming bytes are dealt in turn to a number of branches. The branch count is called the branch count, and each branch delays its bytes by a whole number of visits. The first branch has the longest delay, `(branches-1)*cell_depth` visits. Each later branch is `cell_depth` visits shorter, and the last branch passes its bytes straight through. After the fill period, every byte therefore leaves the block with the same total delay, and the original byte order is restored.

All branch delay lines share one byte array. Each branch owns a contiguous region of the array and keeps its own circular pointer into that region. Only branches that have a nonzero delay use the array. The total storage is `cell_depth*(branches-1)*branches/2` bytes.

The upstream frame synchronizer marks the byte at the start of each block with a sync flag. The block accepts no data until it sees the first sync byte. Branch count and cell depth are taken from the input pins only when a restart happens.

Top module: `conv_deinterleaver`

## Requirements
- R1: After reset `valid_o` is 0 and `byte_o` is 0.
- R2: Before the first byte that has `sync_i` set, bytes with `valid_i` high are ignored and `valid_o` stays 0.
- R3: Number the accepted bytes from the most recent restart as n = 0, 1, 2, and so on. Byte n goes to branch k = n mod I. One clock after byte n is accepted, `byte_o` carries the byte that was accepted at index n - (I-1-k)*J*I. The last branch has zero delay, so it outputs byte n itself.
- R4: After a restart, `valid_o` stays 0 for the first (I-1)*J*I accepted bytes. After that, `valid_o` is 1 exactly one clock after each accepted byte.
- R5: A cycle with `valid_i` low changes no state, and in the following cycle `valid_o` is 0.
- R6: A sync byte that falls on branch 0 while `branches_i` and `cell_depth_i` equal the configuration in use is treated as ordinary data. It does not restart the block.
- R7: A restart happens when a sync byte arrives and any of these holds: the block is not yet armed, the branch is not 0, or `branches_i` or `cell_depth_i` differs from the configuration in use. A restart latches the new I and J, clears every branch pointer, and makes that sync byte n = 0.
- R8: Changes on `branches_i` or `cell_depth_i` without a restart have no effect on the output.
- R9: The supported ranges are 2 <= I <= MAX_I and 1 <= J <= MAX_J, with J*(I-1)*I/2 <= MEM_DEPTH. Both the smallest setting (I=2, J=1) and the largest setting (I=16, J=32) de-interleave correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_i | input | 8 | Interleaved input byte |
| valid_i | input | 1 | `byte_i` is valid in this cycle |
| sync_i | input | 1 | This byte starts a block (sync byte) |
| branches_i | input | $clog2(MAX_I+1) | Branch count I, latched at restart |
| cell_depth_i | input | $clog2(MAX_J+1) | Cell depth J, latched at restart |
| byte_o | output | 8 | De-interleaved byte |
| valid_o | output | 1 | `byte_o` holds a valid de-interleaved byte |

## Verification
Internal faults show up at the ports in different ways and at different times:
- A wrong commutator index or a wrong region base places bytes from one branch into another branch's storage. This corrupts `byte_o` as soon as the first delayed byte of the affected branch comes out, which is at most (I-1)*J*I bytes after the restart.
- A pointer that wraps at the wrong depth changes the delay of that branch. The error appears on the first valid output from that branch.
- A fill counter that is off by any amount moves the first rising edge of `valid_o` away from byte (I-1)*J*I.
- Restart decisions are observed by sending aligned sync bytes, misaligned sync bytes and sync bytes with a changed configuration. Each case either keeps the output stream continuous or reopens the fill window.

// File: rtl/dil_pkg.sv
package dil_pkg;
  typedef logic [7:0] byte_t;

  function automatic int unsigned storage_bytes(input int unsigned i, input int unsigned j);
    return (j * (i - 1) * i) / 2;
  endfunction
endpackage

// File: rtl/dil_ram.sv
module dil_ram
  import dil_pkg::*;
#(
  parameter int unsigned DEPTH = 4096,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  byte_t         wdata_i,
  output byte_t         rdata_o
);
  byte_t mem_q [DEPTH];

  // read returns the old byte; the write lands at the edge
  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end
endmodule

// File: rtl/dil_sequencer.sv
module dil_sequencer
  import dil_pkg::*;
#(
  parameter int unsigned MAX_I = 16,
  parameter int unsigned MAX_J = 32,
  parameter int unsigned MEM_DEPTH = 4096,
  parameter int unsigned DEF_I = 12,
  parameter int unsigned DEF_J = 17,
  localparam int unsigned IW = $clog2(MAX_I + 1),
  localparam int unsigned JW = $clog2(MAX_J + 1),
  localparam int unsigned DW = $clog2((MAX_I - 1) * MAX_J + 1),
  localparam int unsigned BW = $clog2(MEM_DEPTH) + 1,
  localparam int unsigned FW = $clog2((MAX_I - 1) * MAX_J * MAX_I + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          sync_i,
  input  logic [IW-1:0] branches_i,
  input  logic [JW-1:0] cell_depth_i,
  output logic          accept_o,
  output logic          restart_o,
  output logic [IW-1:0] branch_o,
  output logic [BW-1:0] base_o,
  output logic [DW-1:0] depth_o,
  output logic          emit_ok_o
);
  logic          armed_q;
  logic [IW-1:0] cfg_i_q, branch_q;
  logic [JW-1:0] cfg_j_q;
  logic [BW-1:0] base_q;
  logic [DW-1:0] depth_q, depth0_q;
  logic [FW-1:0] fill_q, cnt_q;

  logic          cfg_change, last;
  logic [DW-1:0] depth0_new;
  logic [FW-1:0] fill_new;
  logic [IW-1:0] cur_i;
  logic [JW-1:0] cur_j;
  logic [DW-1:0] cur_depth0;
  logic [FW-1:0] cur_fill, cur_cnt;

  assign cfg_change = (branches_i != cfg_i_q) || (cell_depth_i != cfg_j_q);
  assign restart_o  = valid_i && sync_i && (!armed_q || (branch_q != '0) || cfg_change);
  assign accept_o   = valid_i && (armed_q || restart_o);

  assign depth0_new = DW'(branches_i - IW'(1)) * DW'(cell_depth_i);
  assign fill_new   = FW'(depth0_new) * FW'(branches_i);

  assign cur_i      = restart_o ? branches_i   : cfg_i_q;
  assign cur_j      = restart_o ? cell_depth_i : cfg_j_q;
  assign cur_depth0 = restart_o ? depth0_new   : depth0_q;
  assign cur_fill   = restart_o ? fill_new     : fill_q;
  assign cur_cnt    = restart_o ? '0           : cnt_q;
  assign branch_o   = restart_o ? '0           : branch_q;
  assign base_o     = restart_o ? '0           : base_q;
  assign depth_o    = restart_o ? depth0_new   : depth_q;

  assign last      = (branch_o == cur_i - IW'(1));
  assign emit_ok_o = (cur_cnt >= cur_fill);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      cfg_i_q  <= IW'(DEF_I);
      cfg_j_q  <= JW'(DEF_J);
      branch_q <= '0;
      base_q   <= '0;
      depth_q  <= '0;
      depth0_q <= '0;
      fill_q   <= '0;
      cnt_q    <= '0;
    end else if (accept_o) begin
      armed_q  <= 1'b1;
      cfg_i_q  <= cur_i;
      cfg_j_q  <= cur_j;
      depth0_q <= cur_depth0;
      fill_q   <= cur_fill;
      cnt_q    <= emit_ok_o ? cur_cnt : cur_cnt + FW'(1);
      branch_q <= last ? '0 : branch_o + IW'(1);
      base_q   <= last ? '0 : base_o + BW'(depth_o);
      depth_q  <= last ? cur_depth0 : depth_o - DW'(cur_j);
    end
  end

  assert_branch_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> branch_q < cfg_i_q);
  assert_idle_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(branch_q) && $stable(cnt_q) && $stable(base_q));
  assert_restart_steps_to_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> branch_q == IW'(1));
  assert_cfg_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> (branches_i >= IW'(2)) && (32'(branches_i) <= MAX_I) &&
                  (cell_depth_i != '0) && (32'(cell_depth_i) <= MAX_J) &&
                  (storage_bytes(32'(branches_i), 32'(cell_depth_i)) <= MEM_DEPTH));
endmodule

// File: rtl/dil_ptr_bank.sv
module dil_ptr_bank #(
  parameter int unsigned MAX_I = 16,
  parameter int unsigned MAX_J = 32,
  localparam int unsigned IW = $clog2(MAX_I + 1),
  localparam int unsigned SW = $clog2(MAX_I),
  localparam int unsigned DW = $clog2((MAX_I - 1) * MAX_J + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          restart_i,
  input  logic [IW-1:0] branch_i,
  input  logic [DW-1:0] depth_i,
  output logic [DW-1:0] ptr_o
);
  logic [DW-1:0] ptr_q [MAX_I];
  logic [DW-1:0] ptr_nxt;

  assign ptr_o   = restart_i ? '0 : ptr_q[branch_i[SW-1:0]];
  assign ptr_nxt = (depth_i == '0 || ptr_o + DW'(1) == depth_i) ? '0 : ptr_o + DW'(1);

  for (genvar g = 0; g < MAX_I; g++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q[g] <= '0;
      end else if (accept_i && branch_i == IW'(g)) begin
        ptr_q[g] <= ptr_nxt;
      end else if (accept_i && restart_i) begin
        ptr_q[g] <= '0;
      end
    end
  end

  assert_ptr_below_depth_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && depth_i != '0) |-> ptr_o < depth_i);
endmodule

// File: rtl/conv_deinterleaver.sv
module conv_deinterleaver
  import dil_pkg::*;
#(
  parameter int unsigned MAX_I = 16,
  parameter int unsigned MAX_J = 32,
  parameter int unsigned MEM_DEPTH = 4096,
  parameter int unsigned DEF_I = 12,
  parameter int unsigned DEF_J = 17,
  localparam int unsigned IW = $clog2(MAX_I + 1),
  localparam int unsigned JW = $clog2(MAX_J + 1),
  localparam int unsigned DW = $clog2((MAX_I - 1) * MAX_J + 1),
  localparam int unsigned AW = $clog2(MEM_DEPTH),
  localparam int unsigned BW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    byte_i,
  input  logic          valid_i,
  input  logic          sync_i,
  input  logic [IW-1:0] branches_i,
  input  logic [JW-1:0] cell_depth_i,
  output logic [7:0]    byte_o,
  output logic          valid_o
);
  logic          accept, restart, emit_ok, we;
  logic [IW-1:0] branch;
  logic [BW-1:0] base, addr;
  logic [DW-1:0] depth, ptr;
  byte_t         rdata, out_byte;

  dil_sequencer #(
    .MAX_I(MAX_I), .MAX_J(MAX_J), .MEM_DEPTH(MEM_DEPTH), .DEF_I(DEF_I), .DEF_J(DEF_J)
  ) u_seq (
    .clk_i, .rst_ni, .valid_i, .sync_i, .branches_i, .cell_depth_i,
    .accept_o(accept), .restart_o(restart), .branch_o(branch),
    .base_o(base), .depth_o(depth), .emit_ok_o(emit_ok)
  );

  dil_ptr_bank #(.MAX_I(MAX_I), .MAX_J(MAX_J)) u_ptr (
    .clk_i, .rst_ni, .accept_i(accept), .restart_i(restart),
    .branch_i(branch), .depth_i(depth), .ptr_o(ptr)
  );

  assign addr = base + BW'(ptr);
  assign we   = accept && (depth != '0);

  dil_ram #(.DEPTH(MEM_DEPTH)) u_ram (
    .clk_i, .we_i(we), .addr_i(addr[AW-1:0]), .wdata_i(byte_i), .rdata_o(rdata)
  );

  assign out_byte = (depth == '0) ? byte_i : rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= accept && emit_ok;
      if (accept) byte_o <= out_byte;
    end
  end

  assert_addr_in_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> addr < BW'(MEM_DEPTH));
  assert_valid_needs_input_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_restart_opens_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> !valid_o);
endmodule

// File: tb/tb_conv_deinterleaver.sv
module tb_conv_deinterleaver;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_i = '0;
  logic       valid_i = 1'b0;
  logic       sync_i = 1'b0;
  logic [4:0] branches_i = 5'd12;
  logic [5:0] cell_depth_i = 6'd17;
  logic [7:0] byte_o;
  logic       valid_o;

  int checks = 0;
  int errors = 0;

  // reference model state (from the requirements)
  bit         armed = 0;
  int         n = 0;
  int         cur_i = 0;
  int         cur_j = 0;
  logic [7:0] hist [0:16383];
  int         seed = 1;

  always #5 clk_i = ~clk_i;

  conv_deinterleaver dut (
    .clk_i, .rst_ni, .byte_i, .valid_i, .sync_i, .branches_i, .cell_depth_i,
    .byte_o, .valid_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, predict, check at next negedge
  task automatic send(input logic [7:0] b, input bit s, input bit v, input string tag);
    bit exp_v;
    logic [7:0] exp_b;
    string req;
    exp_v = 0;
    exp_b = '0;
    req = tag;
    valid_i = v;
    sync_i = s;
    byte_i = b;
    if (v) begin
      if (s && (!armed || (n % cur_i) != 0 ||
                int'(branches_i) != cur_i || int'(cell_depth_i) != cur_j)) begin
        armed = 1;
        cur_i = int'(branches_i);
        cur_j = int'(cell_depth_i);
        n = 0;
      end
      if (armed) begin
        int fill;
        hist[n] = b;
        fill = (cur_i - 1) * cur_j * cur_i;
        if (n >= fill) begin
          int k;
          k = n % cur_i;
          exp_v = 1;
          exp_b = hist[n - (cur_i - 1 - k) * cur_j * cur_i];
        end else begin
          req = {tag, "/R4"};
        end
        n++;
      end
    end
    @(negedge clk_i);
    check(valid_o == exp_v, req, int'(valid_o), int'(exp_v));
    if (exp_v) check(byte_o == exp_b, req, int'(byte_o), int'(exp_b));
  endtask

  function automatic logic [7:0] next_byte();
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return 8'(seed >> 16);
  endfunction

  task automatic t_reset_R1();
    @(negedge clk_i);
    check(valid_o == 1'b0, "R1", int'(valid_o), 0);
    check(byte_o == 8'h00, "R1", int'(byte_o), 0);
  endtask

  task automatic t_pre_sync_R2();
    for (int i = 0; i < 20; i++) send(next_byte(), 1'b0, 1'b1, "R2");
  endtask

  // default config, aligned sync every 204 bytes
  task automatic t_default_R3_R6();
    for (int i = 0; i < 2700; i++)
      send((i % 204 == 0) ? 8'h47 : next_byte(), (i % 204 == 0), 1'b1,
           (i % 204 == 0 && i != 0) ? "R6" : "R3");
  endtask

  task automatic t_gaps_R5();
    for (int i = 0; i < 120; i++) begin
      send(next_byte(), 1'b0, 1'b1, "R3");
      if (i % 3 == 0) send(next_byte(), 1'b1, 1'b0, "R5");
    end
  endtask

  task automatic t_cfg_ignored_R8();
    branches_i = 5'd5;
    cell_depth_i = 6'd3;
    for (int i = 0; i < 150; i++) send(next_byte(), 1'b0, 1'b1, "R8");
  endtask

  task automatic t_restart_R7();
    // new config via sync (R8 inputs still 5/3 -> differ from 12/17)
    branches_i = 5'd3;
    cell_depth_i = 6'd2;
    for (int i = 0; i < 60; i++) send(next_byte(), (i == 0), 1'b1, "R7");
    // misaligned sync: 61 bytes since restart, branch 1
    send(next_byte(), 1'b0, 1'b1, "R7");
    for (int i = 0; i < 40; i++) send(next_byte(), (i == 0), 1'b1, "R7");
  endtask

  task automatic t_range_R9();
    branches_i = 5'd2;
    cell_depth_i = 6'd1;
    for (int i = 0; i < 30; i++) send(next_byte(), (i == 0), 1'b1, "R9");
    branches_i = 5'd16;
    cell_depth_i = 6'd32;
    for (int i = 0; i < 7900; i++) send(next_byte(), (i == 0), 1'b1, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset_R1();
    t_pre_sync_R2();
    t_default_R3_R6();
    t_gaps_R5();
    t_cfg_ignored_R8();
    t_restart_R7();
    t_range_R9();
    valid_i = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule